// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when a battery-free SRAM copies its contents into nonvolatile cells (a store) or reloads them from those cells (a recall), and it times each phase of those operations. Requests arrive from five places: a software store pulse, a software recall pulse, an external device pulling the shared open-drain busy line low, a power-fail flag (supply under the switch threshold) and a power-reset flag (supply under the reset threshold). The block tracks whether the SRAM has been written since the last nonvolatile operation. It pulls the busy line low while a store runs. It also tells the SRAM port when reads and writes are allowed.

Every duration is a parameter counted in clock cycles. A store is an erase phase followed by a program phase. A software recall is an SRAM clear followed by a transfer. A power-up recall is one transfer phase. Stores started by hardware or by power loss run only when the SRAM is dirty. A software store always runs. Whenever a recall is pending, the supply dipped to the reset level, and the recall runs once the power-fail flag drops.

The controller has eleven states. IDLE allows all access. HW_GRACE allows reads and blocks writes while a hardware request waits. PF_PULSE pulls the busy line low after power loss. ERASE and PROGRAM make up a store. HW_HOLD keeps the part disabled until the busy line is released. RECOVER is a short wait before access resumes. BROWN keeps the part disabled while power is low. RCL_CLEAR and RCL_XFER make up a software recall. RESTORE is the recall after power returns.

The transitions are:
- IDLE goes to PF_PULSE on power fail. Otherwise it goes to RESTORE on a pending recall, then to HW_GRACE on a low busy line, then to ERASE on a software store, then to RCL_CLEAR on a software recall.
- HW_GRACE goes to ERASE if the SRAM is dirty, or to HW_HOLD if it is clean.
- PF_PULSE goes to ERASE if the SRAM is dirty. It goes to BROWN if the SRAM is clean or if the line never fell.
- ERASE goes to PROGRAM.
- PROGRAM goes to IDLE for a software store, to HW_HOLD for a hardware store and to BROWN for a power-fail store.
- HW_HOLD goes to RECOVER when the line is high, and RECOVER goes to IDLE.
- BROWN goes to RESTORE or to IDLE when power-fail drops.
- RCL_CLEAR goes to RCL_XFER, and RCL_XFER and RESTORE both go to IDLE.

Top module: `nv_xfer_sequencer`

## Requirements
- R1: After reset the block is in IDLE: rd_allow=1, wr_allow=1, busy_drive_low=0, and nv_erase, nv_program, sram_clear and nv_xfer are all 0.
- R2: A software store pulse in IDLE runs even when the SRAM is clean. nv_erase is high for ERASE_CYC cycles, then nv_program is high for PROG_CYC cycles. busy_drive_low is 1 and rd_allow is 0 throughout. The block then returns to IDLE.
- R3: A software recall pulse in IDLE holds sram_clear high for CLR_CYC cycles, then nv_xfer high for XFER_CYC cycles. Access is disabled throughout and the busy line is not driven.
- R4: The dirty flag is set by a sram_wr_done pulse. It is cleared when any store or recall completes. A hardware or power-fail store with a clean flag performs no erase.
- R5: A low busy_in in IDLE starts a grace window of GRACE_CYC cycles with rd_allow=1 and wr_allow=0. After the window a store follows if the SRAM is dirty; otherwise the store is skipped.
- R6: After a hardware-requested store completes, or is skipped, rd_allow and wr_allow stay 0 until busy_in is seen high. Access resumes RECOVER_CYC cycles after that.
- R7: When pwr_fail is 1 in IDLE, busy_drive_low is 1 for PULSE_CYC cycles. If the SRAM is dirty, the store follows with the line still driven low. If it is clean, the line is released and no store occurs. In both cases access stays disabled until pwr_fail returns to 0.
- R8: A recall is pending once pwr_reset has been 1. When pwr_fail is 0 the pending recall holds nv_xfer high for RESTORE_CYC cycles, and the block then returns to IDLE. A power loss without pwr_reset leads straight back to IDLE.
- R9: If busy_in is still high after SENSE_CYC cycles of driving it low in PF_PULSE, the attempt is abandoned with no erase, and the dirty flag is kept.
- R10: In IDLE the requests rank as follows, highest first: power fail, pending recall, busy-line request, software store, software recall.
- R11: Software request pulses that arrive outside IDLE are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_store_req | input | 1 | Software store request pulse |
| sw_recall_req | input | 1 | Software recall request pulse |
| sram_wr_done | input | 1 | Pulse marking a completed SRAM write |
| pwr_fail | input | 1 | Supply below the switch threshold |
| pwr_reset | input | 1 | Supply below the reset threshold |
| busy_in | input | 1 | Sensed level of the shared busy line (1 = high) |
| busy_drive_low | output | 1 | Enables the open-drain pull-down on the busy line |
| rd_allow | output | 1 | SRAM reads permitted |
| wr_allow | output | 1 | SRAM writes permitted |
| nv_erase | output | 1 | Store erase phase active |
| nv_program | output | 1 | Store program phase active |
| sram_clear | output | 1 | Recall clear phase active |
| nv_xfer | output | 1 | Recall transfer phase active (software or power-up) |

## Verification
The hardest case to reach is the abandoned power-fail store, because the block's own pull-down normally brings the busy line low. The bench models the shared line as a wired-AND of the block's pull-down and an external pull. It adds a separate override that holds the line high, much as a strong external driver would. With the override on, the bench raises pwr_fail on a dirty SRAM, checks that the line is driven for only SENSE_CYC cycles with no erase, and then confirms through a later hardware request that the dirty flag was kept. The ranking of requests is reached by raising several request inputs on the same cycle.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_HW_GRACE,
        S_PF_PULSE,
        S_ERASE,
        S_PROGRAM,
        S_HW_HOLD,
        S_RECOVER,
        S_BROWN,
        S_RCL_CLEAR,
        S_RCL_XFER,
        S_RESTORE
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_SW,
        SRC_HW,
        SRC_PF
    } store_src_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nv_phase_timer.sv
module nv_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    output logic [CW-1:0] elapsed_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            elapsed_o <= '0;
        else if (restart_i)
            elapsed_o <= '0;
        else if (elapsed_o != {CW{1'b1}})
            elapsed_o <= elapsed_o + 1'b1;
    end

    // R2: every phase is measured from zero after a state change
    a_r2_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (elapsed_o == '0));

endmodule

// File: rtl/nv_dirty_track.sv
module nv_dirty_track (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_done_i,
    input  logic clear_i,
    output logic dirty_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dirty_o <= 1'b0;
        else if (clear_i)
            dirty_o <= 1'b0;
        else if (wr_done_i)
            dirty_o <= 1'b1;
    end

    a_r4_clear_after_completion: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !dirty_o);

    a_r4_set_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done_i && !clear_i) |=> dirty_o);

endmodule

// File: rtl/nv_xfer_sequencer.sv
module nv_xfer_sequencer
    import nv_seq_pkg::*;
#(
    parameter int GRACE_CYC   = 200,
    parameter int PULSE_CYC   = 200,
    parameter int SENSE_CYC   = 20,
    parameter int ERASE_CYC   = 1000000,
    parameter int PROG_CYC    = 1000000,
    parameter int CLR_CYC     = 2000,
    parameter int XFER_CYC    = 2000,
    parameter int RESTORE_CYC = 110000,
    parameter int RECOVER_CYC = 140
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic sram_wr_done,
    input  logic pwr_fail,
    input  logic pwr_reset,
    input  logic busy_in,
    output logic busy_drive_low,
    output logic rd_allow,
    output logic wr_allow,
    output logic nv_erase,
    output logic nv_program,
    output logic sram_clear,
    output logic nv_xfer
);

    localparam int MAX_A = max_of(max_of(GRACE_CYC, PULSE_CYC), max_of(ERASE_CYC, PROG_CYC));
    localparam int MAX_B = max_of(max_of(CLR_CYC, XFER_CYC), max_of(RESTORE_CYC, RECOVER_CYC));
    localparam int CW    = $clog2(max_of(MAX_A, MAX_B) + 1);

    localparam logic [CW-1:0] L_GRACE   = CW'(GRACE_CYC - 1);
    localparam logic [CW-1:0] L_PULSE   = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] L_SENSE   = CW'(SENSE_CYC - 1);
    localparam logic [CW-1:0] L_ERASE   = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] L_PROG    = CW'(PROG_CYC - 1);
    localparam logic [CW-1:0] L_CLR     = CW'(CLR_CYC - 1);
    localparam logic [CW-1:0] L_XFER    = CW'(XFER_CYC - 1);
    localparam logic [CW-1:0] L_RESTORE = CW'(RESTORE_CYC - 1);
    localparam logic [CW-1:0] L_RECOVER = CW'(RECOVER_CYC - 1);

    seq_state_e    state_q, state_d;
    store_src_e    src_q, src_d;
    logic          recall_pend_q;
    logic          dirty;
    logic          done;
    logic          dirty_clr;
    logic [CW-1:0] elapsed;
    logic [CW-1:0] lim;

    nv_phase_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (state_d != state_q),
        .elapsed_o (elapsed)
    );

    nv_dirty_track u_dirty (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_done_i (sram_wr_done),
        .clear_i   (dirty_clr),
        .dirty_o   (dirty)
    );

    always_comb begin
        unique case (state_q)
            S_HW_GRACE:  lim = L_GRACE;
            S_PF_PULSE:  lim = L_PULSE;
            S_ERASE:     lim = L_ERASE;
            S_PROGRAM:   lim = L_PROG;
            S_RCL_CLEAR: lim = L_CLR;
            S_RCL_XFER:  lim = L_XFER;
            S_RESTORE:   lim = L_RESTORE;
            S_RECOVER:   lim = L_RECOVER;
            default:     lim = '0;
        endcase
    end

    assign done      = (elapsed == lim);
    assign dirty_clr = done && (state_q == S_PROGRAM || state_q == S_RCL_XFER ||
                                state_q == S_RESTORE);

    // next-state process
    always_comb begin
        state_d = state_q;
        src_d   = src_q;
        unique case (state_q)
            S_IDLE: begin
                if (pwr_fail) begin
                    state_d = S_PF_PULSE;
                    src_d   = SRC_PF;
                end else if (recall_pend_q || pwr_reset) begin
                    state_d = S_RESTORE;
                end else if (!busy_in) begin
                    state_d = S_HW_GRACE;
                    src_d   = SRC_HW;
                end else if (sw_store_req) begin
                    state_d = S_ERASE;
                    src_d   = SRC_SW;
                end else if (sw_recall_req) begin
                    state_d = S_RCL_CLEAR;
                end
            end
            S_HW_GRACE:  if (done) state_d = dirty ? S_ERASE : S_HW_HOLD;
            S_PF_PULSE: begin
                if (elapsed == L_SENSE && busy_in) state_d = S_BROWN;
                else if (done)                     state_d = dirty ? S_ERASE : S_BROWN;
            end
            S_ERASE:     if (done) state_d = S_PROGRAM;
            S_PROGRAM: begin
                if (done) begin
                    unique case (src_q)
                        SRC_HW:  state_d = S_HW_HOLD;
                        SRC_PF:  state_d = S_BROWN;
                        default: state_d = S_IDLE;
                    endcase
                end
            end
            S_HW_HOLD:   if (busy_in) state_d = S_RECOVER;
            S_RECOVER:   if (done) state_d = S_IDLE;
            S_BROWN: begin
                if (!pwr_fail) state_d = (recall_pend_q || pwr_reset) ? S_RESTORE : S_IDLE;
            end
            S_RCL_CLEAR: if (done) state_d = S_RCL_XFER;
            S_RCL_XFER:  if (done) state_d = S_IDLE;
            S_RESTORE:   if (done) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= S_IDLE;
            src_q         <= SRC_SW;
            recall_pend_q <= 1'b0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            if (pwr_reset)
                recall_pend_q <= 1'b1;
            else if (state_q == S_RESTORE && done)
                recall_pend_q <= 1'b0;
        end
    end

    // output process
    always_comb begin
        busy_drive_low = 1'b0;
        rd_allow       = 1'b0;
        wr_allow       = 1'b0;
        nv_erase       = 1'b0;
        nv_program     = 1'b0;
        sram_clear     = 1'b0;
        nv_xfer        = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                rd_allow = 1'b1;
                wr_allow = !pwr_fail;
            end
            S_HW_GRACE:  rd_allow = 1'b1;
            S_PF_PULSE:  busy_drive_low = 1'b1;
            S_ERASE: begin
                busy_drive_low = 1'b1;
                nv_erase       = 1'b1;
            end
            S_PROGRAM: begin
                busy_drive_low = 1'b1;
                nv_program     = 1'b1;
            end
            S_RCL_CLEAR: sram_clear = 1'b1;
            S_RCL_XFER:  nv_xfer = 1'b1;
            S_RESTORE:   nv_xfer = 1'b1;
            default: ;
        endcase
    end

    // R2: the program phase always follows the erase phase
    a_r2_erase_then_program: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_erase) |-> nv_program);

    // R3: the transfer phase always follows the clear phase
    a_r3_clear_then_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_clear) |-> nv_xfer);

    // R5: the grace window opens only after the busy line was low
    a_r5_grace_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_HW_GRACE) |-> $past(!busy_in));

    // R6: the hold state persists while the busy line stays low
    a_r6_hold_until_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HW_HOLD && !busy_in) |=> (state_q == S_HW_HOLD));

    // R7: power fail in IDLE always starts the busy pulse
    a_r7_pf_starts_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && pwr_fail) |=> (state_q == S_PF_PULSE));

    // R8: a restore begins only with a recall pending
    a_r8_restore_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == S_RESTORE) |-> $past(recall_pend_q || pwr_reset));

endmodule

// File: tb/nv_xfer_sequencer_bench.sv
`timescale 1ns/1ps
module nv_xfer_sequencer_bench;

    localparam int GRACE   = 6;
    localparam int PULSE   = 8;
    localparam int SENSE   = 2;
    localparam int ERASE   = 10;
    localparam int PROG    = 12;
    localparam int CLR     = 4;
    localparam int XFER    = 5;
    localparam int RESTORE = 15;
    localparam int RECOVER = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_store_req = 1'b0, sw_recall_req = 1'b0, sram_wr_done = 1'b0;
    logic pwr_fail = 1'b0, pwr_reset = 1'b0;
    logic ext_pull = 1'b0, hold_high = 1'b0;
    logic busy_in, busy_drive_low, rd_allow, wr_allow;
    logic nv_erase, nv_program, sram_clear, nv_xfer;
    int   total = 0, bad = 0;
    bit   finished = 1'b0;

    always #2.5 clk = ~clk;

    assign busy_in = hold_high ? 1'b1 : !(busy_drive_low || ext_pull);

    nv_xfer_sequencer #(
        .GRACE_CYC(GRACE), .PULSE_CYC(PULSE), .SENSE_CYC(SENSE),
        .ERASE_CYC(ERASE), .PROG_CYC(PROG), .CLR_CYC(CLR), .XFER_CYC(XFER),
        .RESTORE_CYC(RESTORE), .RECOVER_CYC(RECOVER)
    ) u_nv_xfer_sequencer (
        .clk(clk), .rst_n(rst_n),
        .sw_store_req(sw_store_req), .sw_recall_req(sw_recall_req),
        .sram_wr_done(sram_wr_done), .pwr_fail(pwr_fail), .pwr_reset(pwr_reset),
        .busy_in(busy_in), .busy_drive_low(busy_drive_low),
        .rd_allow(rd_allow), .wr_allow(wr_allow),
        .nv_erase(nv_erase), .nv_program(nv_program),
        .sram_clear(sram_clear), .nv_xfer(nv_xfer)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int sel);
        case (sel)
            0:       return nv_erase;
            1:       return nv_program;
            2:       return sram_clear;
            3:       return nv_xfer;
            4:       return busy_drive_low;
            5:       return rd_allow && !wr_allow;
            6:       return !rd_allow;
            default: return busy_drive_low && !nv_erase;
        endcase
    endfunction

    task automatic count_while(input int sel, output int n);
        n = 0;
        while (sig(sel) && n < 5000) begin
            n++;
            tick();
        end
    endtask

    task automatic write_once();
        sram_wr_done = 1'b1;
        tick();
        sram_wr_done = 1'b0;
        tick();
    endtask

    task automatic store_phases(input string req);
        int n;
        chk({req, " erase starts"}, nv_erase, 1);
        chk({req, " busy driven"}, busy_drive_low, 1);
        chk({req, " reads off"}, rd_allow, 0);
        count_while(0, n);
        chk({req, " erase length"}, n, ERASE);
        count_while(1, n);
        chk({req, " program length"}, n, PROG);
    endtask

    // hardware request cycle: grace, optional store, hold, recovery
    task automatic hw_cycle(input string req, input bit expect_store, input bit poke_sw);
        int n;
        ext_pull = 1'b1;
        tick();
        chk("R5 grace reads on", rd_allow, 1);
        chk("R5 grace writes off", wr_allow, 0);
        count_while(5, n);
        chk("R5 grace length", n, GRACE);
        chk({req, " store decision"}, nv_erase, int'(expect_store));
        if (expect_store) store_phases(req);
        repeat (3) tick();
        chk("R6 held while line low", rd_allow, 0);
        ext_pull = 1'b0;
        tick();
        if (poke_sw) begin
            sw_store_req = 1'b1;
            tick();
            sw_store_req = 1'b0;
            count_while(6, n);
            chk("R6 recover length", n, RECOVER - 1);
        end else begin
            count_while(6, n);
            chk("R6 recover length", n, RECOVER);
        end
        chk("R6 access resumes", wr_allow, 1);
    endtask

    task automatic t_reset();
        chk("R1 rd_allow", rd_allow, 1);
        chk("R1 wr_allow", wr_allow, 1);
        chk("R1 busy released", busy_drive_low, 0);
        chk("R1 phases idle", {nv_erase, nv_program, sram_clear, nv_xfer}, 0);
    endtask

    task automatic t_sw_store();
        sw_store_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        store_phases("R2");
        chk("R2 back to idle", rd_allow && wr_allow, 1);
    endtask

    task automatic t_sw_recall();
        int n;
        sw_recall_req = 1'b1;
        tick();
        sw_recall_req = 1'b0;
        chk("R3 clear starts", sram_clear, 1);
        chk("R3 busy not driven", busy_drive_low, 0);
        chk("R3 access off", rd_allow, 0);
        count_while(2, n);
        chk("R3 clear length", n, CLR);
        count_while(3, n);
        chk("R3 transfer length", n, XFER);
        chk("R3 back to idle", rd_allow, 1);
    endtask

    task automatic t_pf_clean();
        int n;
        pwr_fail = 1'b1;
        tick();
        count_while(4, n);
        chk("R7 clean pulse length", n, PULSE);
        chk("R7 clean no store", nv_erase, 0);
        repeat (3) tick();
        chk("R7 disabled in brown-out", rd_allow || wr_allow, 0);
        pwr_fail = 1'b0;
        tick();
        chk("R8 no recall without reset", nv_xfer, 0);
        chk("R8 idle after brown-out", rd_allow && wr_allow, 1);
    endtask

    task automatic t_pf_dirty_reset();
        int n;
        write_once();
        pwr_fail = 1'b1;
        pwr_reset = 1'b1;
        tick();
        count_while(7, n);
        chk("R7 dirty pulse length", n, PULSE);
        pwr_reset = 1'b0;
        store_phases("R7");
        chk("R7 disabled after store", rd_allow, 0);
        tick();
        pwr_fail = 1'b0;
        tick();
        count_while(3, n);
        chk("R8 restore length", n, RESTORE);
        chk("R8 idle after restore", rd_allow && wr_allow, 1);
    endtask

    task automatic t_abandon();
        int n;
        write_once();
        hold_high = 1'b1;
        pwr_fail = 1'b1;
        tick();
        count_while(4, n);
        chk("R9 drive stops at sense", n, SENSE);
        chk("R9 no erase", nv_erase, 0);
        chk("R9 still disabled", rd_allow, 0);
        pwr_fail = 1'b0;
        hold_high = 1'b0;
        tick();
        chk("R9 idle", rd_allow, 1);
        hw_cycle("R9 dirty kept", 1'b1, 1'b0);
    endtask

    task automatic t_priority();
        int n;
        // pending recall beats busy-line request and software store
        pwr_reset = 1'b1;
        ext_pull = 1'b1;
        sw_store_req = 1'b1;
        tick();
        pwr_reset = 1'b0;
        sw_store_req = 1'b0;
        chk("R10 recall first", nv_xfer, 1);
        count_while(3, n);
        chk("R10 restore length", n, RESTORE);
        tick();
        chk("R10 hw request next", rd_allow && !wr_allow, 1);
        count_while(5, n);
        chk("R11 dropped sw store (no erase)", nv_erase, 0);
        ext_pull = 1'b0;
        tick();
        count_while(6, n);
        // power fail beats everything
        ext_pull = 1'b1;
        sw_store_req = 1'b1;
        pwr_fail = 1'b1;
        tick();
        sw_store_req = 1'b0;
        count_while(4, n);
        chk("R10 power fail first", n, PULSE);
        chk("R10 no store when clean", nv_erase, 0);
        ext_pull = 1'b0;
        pwr_fail = 1'b0;
        tick();
        tick();
        chk("R10 idle again", nv_erase || nv_xfer, 0);
        // software store beats software recall
        sw_store_req = 1'b1;
        sw_recall_req = 1'b1;
        tick();
        sw_store_req = 1'b0;
        sw_recall_req = 1'b0;
        store_phases("R10 sw order");
        repeat (3) tick();
        chk("R10 recall dropped", sram_clear, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_sw_store();
        t_sw_recall();
        hw_cycle("R4 clean skip", 1'b0, 1'b0);
        write_once();
        hw_cycle("R4 dirty store", 1'b1, 1'b1);
        repeat (3) tick();
        chk("R11 sw store during recover dropped", nv_erase, 0);
        t_pf_clean();
        t_pf_dirty_reset();
        t_abandon();
        t_priority();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule